// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a set of address translations and resolves a 32-bit virtual address against all of them in parallel. Each stored translation carries a virtual page number, an address-space identifier, a physical page number, a valid flag, a two-bit page-size code, a shared flag, two protection bits and a dirty flag. A request strobe starts a lookup. One clock later the block presents a status (success, miss or multiple hit). On success it also gives the index of the matching slot, the physical address and the protection and dirty bits of that slot.

Each slot compares the address under the mask that its own page-size code selects, so pages of 1 KB, 4 KB, 64 KB and 1 MB can be mixed freely. The identifier comparison is skipped for shared pages. It is also skipped when the requester is privileged and the single-virtual-space flag is set. Slots are loaded through a write port addressed by slot number. A flush input invalidates every slot in one cycle. A replacement pointer steps forward on each lookup that software requested, and wraps to zero at a programmable boundary. Lookups marked as internal leave the pointer alone.

Top module: `utlb_lookup`

## Requirements
- R1: The buffer has 64 slots (parameter N_ENTRIES); a write with wr_en stores all fields into slot wr_idx, a lookup returns the stored protection and dirty bits of the hit slot, and a slot whose valid flag is 0 never matches.
- R2: Page-size code 0 compares address bits [31:10], code 1 bits [31:12], code 2 bits [31:16], code 3 bits [31:20] of {vpn,10'b0} against req_va.
- R3: The identifier is compared only when the slot's shared flag is 0 and (priv_mode is 0 or single_virt is 0); otherwise a page match alone is a hit.
- R4: rsp_status is 2'b00 when exactly one slot matches, 2'b01 when none match and 2'b10 when two or more match; 2'b11 never appears.
- R5: On success rsp_pa equals {ppn,10'b0} on the bits kept by the mask, and req_va on the remaining low bits.
- R6: rsp_idx, rsp_pa, rsp_prot and rsp_dirty are zero whenever rsp_status is not success.
- R7: On each lookup with req_internal 0, repl_ptr becomes repl_ptr+1 (modulo 64), or 0 if that value equals repl_bound; internal lookups and idle cycles leave it unchanged; reset sets it to 0.
- R8: flush clears the valid flag of every slot; a write in the same cycle as a flush still takes effect for its own slot.
- R9: The response appears on the clock edge after the request edge, with rsp_valid high for exactly one cycle per request, and reflects the slot contents before any write in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot number to write |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_asid | input | 8 | Address-space identifier |
| wr_ppn | input | 22 | Physical page number (address bits 31:10) |
| wr_valid | input | 1 | Valid flag |
| wr_size | input | 2 | Page-size code |
| wr_shared | input | 1 | Shared-page flag |
| wr_prot | input | 2 | Protection bits |
| wr_dirty | input | 1 | Dirty flag |
| flush | input | 1 | Invalidate all slots |
| req | input | 1 | Lookup request strobe |
| req_internal | input | 1 | Lookup does not advance the replacement pointer |
| req_va | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Current address-space identifier |
| priv_mode | input | 1 | 1 = privileged requester |
| single_virt | input | 1 | Single-virtual-space flag |
| repl_bound | input | 6 | Replacement pointer wrap value |
| rsp_valid | output | 1 | Response strobe |
| rsp_status | output | 2 | 00 success, 01 miss, 10 multiple hit |
| rsp_idx | output | 6 | Hit slot number |
| rsp_pa | output | 32 | Physical address |
| rsp_prot | output | 2 | Protection bits of hit slot |
| rsp_dirty | output | 1 | Dirty flag of hit slot |
| repl_ptr | output | 6 | Replacement pointer |

## Verification
The bench fills all 64 slots with disjoint pages and probes each one. A wrong index encoder or a crossed physical-address mux would return the wrong slot number or page. It sweeps every page-size code with an address on the last byte inside the page and one just outside it. This catches masks that are off by a bit, which would either miss inside the page or hit outside it. It walks all sixteen combinations of shared flag, privilege, single-virtual flag and identifier equality, where a flawed condition would hit across address spaces. It also forces a duplicate mapping, a flush racing a write, a write racing a lookup, and a pointer sequence that must wrap at the programmed bound; a design that got these wrong would report a false success, lose the written slot, translate through the new contents, or wrap in the wrong place.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 10;
    localparam int PN_W     = VA_W - PG_SHIFT;
    localparam int ASID_W   = 8;

    typedef struct packed {
        logic [PN_W-1:0]   vpn;
        logic [ASID_W-1:0] asid;
        logic [PN_W-1:0]   ppn;
        logic              valid;
        logic [1:0]        size;
        logic              shared;
        logic [1:0]        prot;
        logic              dirty;
    } tlb_slot_t;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_MISS  = 2'b01,
        ST_MULTI = 2'b10
    } lk_status_e;

    // Mask of the address bits that identify the page for a size code.
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] code);
        logic [VA_W-1:0] ones;
        ones = '1;
        case (code)
            2'd0:    return ones << 10;
            2'd1:    return ones << 12;
            2'd2:    return ones << 16;
            default: return ones << 20;
        endcase
    endfunction

endpackage

// File: rtl/tlb_store.sv
`timescale 1ns/1ps
module tlb_store
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_slot_t        wr_data,
    input  logic             flush,
    output tlb_slot_t        slots [N_ENTRIES]
);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g].valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slots[g] <= wr_data;
            end else if (flush) begin
                slots[g].valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tlb_cell.sv
`timescale 1ns/1ps
module tlb_cell
    import tlb_pkg::*;
(
    input  tlb_slot_t         slot,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              priv_mode,
    input  logic              single_virt,
    output logic              hit,
    output logic [VA_W-1:0]   pa
);

    logic [VA_W-1:0] mask;
    logic            page_eq;
    logic            need_asid;

    always_comb begin
        mask      = page_mask(slot.size);
        page_eq   = ((({slot.vpn, {PG_SHIFT{1'b0}}}) ^ va) & mask) == '0;
        need_asid = !slot.shared && (!priv_mode || !single_virt);
        hit       = slot.valid && page_eq && (!need_asid || (slot.asid == cur_asid));
        pa        = ({slot.ppn, {PG_SHIFT{1'b0}}} & mask) | (va & ~mask);
    end

endmodule

// File: rtl/tlb_repl.sv
`timescale 1ns/1ps
module tlb_repl #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [IDX_W-1:0] bound,
    output logic [IDX_W-1:0] ptr
);

    logic [IDX_W-1:0] nxt;
    assign nxt = ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (nxt == bound) ? '0 : nxt;
        end
    end

endmodule

// File: rtl/utlb_lookup.sv
`timescale 1ns/1ps
module utlb_lookup
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PN_W-1:0]   wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PN_W-1:0]   wr_ppn,
    input  logic              wr_valid,
    input  logic [1:0]        wr_size,
    input  logic              wr_shared,
    input  logic [1:0]        wr_prot,
    input  logic              wr_dirty,
    input  logic              flush,
    input  logic              req,
    input  logic              req_internal,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              priv_mode,
    input  logic              single_virt,
    input  logic [IDX_W-1:0]  repl_bound,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [VA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_prot,
    output logic              rsp_dirty,
    output logic [IDX_W-1:0]  repl_ptr
);

    tlb_slot_t             wr_data;
    tlb_slot_t             slots    [N_ENTRIES];
    logic [N_ENTRIES-1:0]  hit_vec;
    logic [N_ENTRIES-1:0]  valid_vec;
    logic [VA_W-1:0]       cell_pa  [N_ENTRIES];
    logic [IDX_W-1:0]      sel_idx;
    logic [VA_W-1:0]       sel_pa;
    logic [1:0]            sel_prot;
    logic                  sel_dirty;
    logic                  one_hit;
    logic                  no_hit;
    lk_status_e            nxt_status;

    always_comb begin
        wr_data.vpn    = wr_vpn;
        wr_data.asid   = wr_asid;
        wr_data.ppn    = wr_ppn;
        wr_data.valid  = wr_valid;
        wr_data.size   = wr_size;
        wr_data.shared = wr_shared;
        wr_data.prot   = wr_prot;
        wr_data.dirty  = wr_dirty;
    end

    tlb_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .flush   (flush),
        .slots   (slots)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cell
        tlb_cell u_cell (
            .slot        (slots[g]),
            .va          (req_va),
            .cur_asid    (cur_asid),
            .priv_mode   (priv_mode),
            .single_virt (single_virt),
            .hit         (hit_vec[g]),
            .pa          (cell_pa[g])
        );
        assign valid_vec[g] = slots[g].valid;
    end

    // OR-reduction is exact when the hit vector is one-hot.
    always_comb begin
        sel_idx   = '0;
        sel_pa    = '0;
        sel_prot  = '0;
        sel_dirty = 1'b0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (hit_vec[i]) begin
                sel_idx   = sel_idx | IDX_W'(i);
                sel_pa    = sel_pa | cell_pa[i];
                sel_prot  = sel_prot | slots[i].prot;
                sel_dirty = sel_dirty | slots[i].dirty;
            end
        end
        no_hit  = (hit_vec == '0);
        one_hit = $onehot(hit_vec);
        if (one_hit)     nxt_status = ST_OK;
        else if (no_hit) nxt_status = ST_MISS;
        else             nxt_status = ST_MULTI;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_status <= ST_MISS;
            rsp_idx    <= '0;
            rsp_pa     <= '0;
            rsp_prot   <= '0;
            rsp_dirty  <= 1'b0;
        end else begin
            rsp_valid <= req;
            if (req) begin
                rsp_status <= nxt_status;
                rsp_idx    <= one_hit ? sel_idx   : '0;
                rsp_pa     <= one_hit ? sel_pa    : '0;
                rsp_prot   <= one_hit ? sel_prot  : '0;
                rsp_dirty  <= one_hit ? sel_dirty : 1'b0;
            end
        end
    end

    tlb_repl #(.IDX_W(IDX_W)) u_repl (
        .clk   (clk),
        .rst   (rst),
        .step  (req && !req_internal),
        .bound (repl_bound),
        .ptr   (repl_ptr)
    );

endmodule

// File: rtl/utlb_lookup_chk.sv
`timescale 1ns/1ps
module utlb_lookup_chk #(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req,
    input logic                 req_internal,
    input logic                 flush,
    input logic                 wr_en,
    input logic                 rsp_valid,
    input logic [1:0]           rsp_status,
    input logic [IDX_W-1:0]     rsp_idx,
    input logic [31:0]          rsp_pa,
    input logic [IDX_W-1:0]     repl_ptr,
    input logic [N_ENTRIES-1:0] valid_vec
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req |=> rsp_valid); // R9

    AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        !req |=> !rsp_valid); // R9

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 2'b11)); // R4

    AST_FAIL_ZEROED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'b00) |-> (rsp_pa == '0 && rsp_idx == '0)); // R6

    AST_REPL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(req && !req_internal) |=> $stable(repl_ptr)); // R7

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flush && !wr_en) |=> (valid_vec == '0)); // R8

endmodule

bind utlb_lookup utlb_lookup_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .req_internal (req_internal),
    .flush        (flush),
    .wr_en        (wr_en),
    .rsp_valid    (rsp_valid),
    .rsp_status   (rsp_status),
    .rsp_idx      (rsp_idx),
    .rsp_pa       (rsp_pa),
    .repl_ptr     (repl_ptr),
    .valid_vec    (valid_vec)
);

// File: tb/tb_utlb_lookup.sv
`timescale 1ns/1ps
module tb_utlb_lookup;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0;
    logic [5:0]  wr_idx = 0;
    logic [21:0] wr_vpn = 0;
    logic [7:0]  wr_asid = 0;
    logic [21:0] wr_ppn = 0;
    logic        wr_valid = 0;
    logic [1:0]  wr_size = 0;
    logic        wr_shared = 0;
    logic [1:0]  wr_prot = 0;
    logic        wr_dirty = 0;
    logic        flush = 0;
    logic        req = 0;
    logic        req_internal = 0;
    logic [31:0] req_va = 0;
    logic [7:0]  cur_asid = 0;
    logic        priv_mode = 0;
    logic        single_virt = 0;
    logic [5:0]  repl_bound = 0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [5:0]  rsp_idx;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_prot;
    logic        rsp_dirty;
    logic [5:0]  repl_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    utlb_lookup dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] vaddr, input logic [7:0] asid,
                      input logic [31:0] paddr, input logic v, input logic [1:0] sz,
                      input logic sh, input logic [1:0] pr, input logic d, input logic fl);
        @(negedge clk);
        wr_en = 1; wr_idx = idx[5:0]; wr_vpn = vaddr[31:10]; wr_asid = asid;
        wr_ppn = paddr[31:10]; wr_valid = v; wr_size = sz; wr_shared = sh;
        wr_prot = pr; wr_dirty = d; flush = fl;
        @(negedge clk);
        wr_en = 0; flush = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic internal);
        @(negedge clk);
        req = 1; req_va = va; req_internal = internal;
        @(negedge clk);
        req = 0; req_internal = 0;
    endtask

    function automatic logic [31:0] msk(input int sz);
        int sh;
        sh = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
        return 32'hFFFF_FFFF << sh;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R9 reset rsp_valid", {31'b0, rsp_valid}, 0);
        chk("R7 reset repl_ptr", {26'b0, repl_ptr}, 0);
        look(32'h1000_0000, 0);
        chk("R1 empty buffer misses", {30'b0, rsp_status}, 2'b01);
        chk("R9 rsp_valid one cycle after req", {31'b0, rsp_valid}, 1);
        @(negedge clk);
        chk("R9 rsp_valid drops", {31'b0, rsp_valid}, 0);

        // R1/R5: fill every slot with a disjoint 4 KB page
        for (int i = 0; i < 64; i++)
            wr(i, 32'h1000_0000 + i * 32'h1_0000, 8'(i), 32'h0800_0000 + i * 32'h2000,
               1, 2'd1, 1, 2'(i), i[0], 0);
        for (int i = 0; i < 64; i++) begin
            look(32'h1000_0000 + i * 32'h1_0000 + i * 4 + 3, 0);
            chk("R4 fill status", {30'b0, rsp_status}, 0);
            chk("R1 fill index", {26'b0, rsp_idx}, i);
            chk("R5 fill pa", rsp_pa, 32'h0800_0000 + i * 32'h2000 + i * 4 + 3);
            chk("R1 fill prot", {30'b0, rsp_prot}, i % 4);
            chk("R1 fill dirty", {31'b0, rsp_dirty}, i % 2);
        end

        // R2: page-size sweep on slot 5
        for (int sz = 0; sz < 4; sz++) begin
            logic [31:0] m, vin, vout;
            m = msk(sz);
            wr(5, 32'h7654_3210, 8'h11, 32'h0ABC_DC00, 1, 2'(sz), 1, 2'b11, 0, 0);
            vin = (32'h7654_3210 & m) | ~m;
            vout = vin ^ (~m + 1);
            look(vin, 0);
            chk("R2 size in-page hit", {30'b0, rsp_status}, 0);
            chk("R5 size pa", rsp_pa, (32'h0ABC_DC00 & m) | ~m);
            look(vout, 0);
            chk("R2 size out-of-page miss", {30'b0, rsp_status}, 2'b01);
        end

        // R3: identifier matrix on slot 5, 4 KB page, asid 3C
        for (int c = 0; c < 16; c++) begin
            logic sh, pv, sv, eq, exp_hit;
            {sh, pv, sv, eq} = 4'(c);
            wr(5, 32'h7654_3000, 8'h3C, 32'h0ABC_D000, 1, 2'd1, sh, 2'b00, 0, 0);
            priv_mode = pv; single_virt = sv; cur_asid = eq ? 8'h3C : 8'h3D;
            exp_hit = eq || !(!sh && (!pv || !sv));
            look(32'h7654_3ABC, 0);
            chk("R3 asid rule", {30'b0, rsp_status}, exp_hit ? 0 : 1);
        end
        priv_mode = 0; single_virt = 0; cur_asid = 8'h3C;

        // R4/R6: duplicate mapping
        wr(9, 32'h7654_3000, 8'h3C, 32'h0DDD_0000, 1, 2'd1, 1, 2'b11, 1, 0);
        look(32'h7654_3ABC, 0);
        chk("R4 multihit status", {30'b0, rsp_status}, 2'b10);
        chk("R6 multihit pa zero", rsp_pa, 0);
        chk("R6 multihit idx zero", {26'b0, rsp_idx}, 0);
        chk("R6 multihit prot zero", {30'b0, rsp_prot}, 0);
        wr(9, 32'h7654_3000, 8'h3C, 32'h0DDD_0000, 0, 2'd1, 1, 2'b11, 1, 0);
        look(32'h7654_3ABC, 0);
        chk("R1 invalid slot ignored idx", {26'b0, rsp_idx}, 5);
        look(32'h7000_0000, 0);
        chk("R6 miss pa zero", rsp_pa, 0);

        // R9: write racing a lookup sees old contents
        @(negedge clk);
        req = 1; req_va = 32'h7654_3ABC;
        wr_en = 1; wr_idx = 5; wr_valid = 0;
        @(negedge clk);
        req = 0; wr_en = 0;
        chk("R9 lookup sees pre-write slot", {30'b0, rsp_status}, 0);
        chk("R9 lookup sees pre-write idx", {26'b0, rsp_idx}, 5);
        look(32'h7654_3ABC, 0);
        chk("R9 later lookup sees write", {30'b0, rsp_status}, 1);

        // R7: replacement pointer after fresh reset
        @(negedge clk); rst = 1; repl_bound = 6'd5;
        @(negedge clk); rst = 0;
        for (int k = 1; k <= 12; k++) begin
            look(32'h0, 0);
            chk("R7 pointer steps and wraps", {26'b0, repl_ptr}, k % 5);
            if (k % 3 == 0) begin
                look(32'h0, 1);
                chk("R7 internal lookup holds pointer", {26'b0, repl_ptr}, k % 5);
            end
        end
        repl_bound = 0;

        // R8: flush
        wr(3, 32'h2000_0000, 0, 32'h0100_0000, 1, 2'd1, 1, 0, 0, 0);
        look(32'h2000_0010, 0);
        chk("R8 slot present before flush", {30'b0, rsp_status}, 0);
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
        look(32'h2000_0010, 0);
        chk("R8 flush invalidates", {30'b0, rsp_status}, 1);
        wr(3, 32'h2000_0000, 0, 32'h0100_0000, 1, 2'd1, 1, 0, 0, 0);
        wr(7, 32'h3000_0000, 0, 32'h0200_0000, 1, 2'd1, 1, 0, 0, 1);
        look(32'h2000_0010, 0);
        chk("R8 flush with write clears others", {30'b0, rsp_status}, 1);
        look(32'h3000_0020, 0);
        chk("R8 same-cycle write survives", {30'b0, rsp_status}, 0);
        chk("R8 same-cycle write pa", rsp_pa, 32'h0200_0020);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule